// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware side of a circular receive descriptor ring for a 10/100 Ethernet MAC. Software places a ring of 16-byte descriptors in memory, gives the engine the ring's base address, and marks each descriptor as owned by hardware. When the first byte of a frame appears on the byte-stream input, the engine fetches the descriptor at its current ring index. If hardware owns that descriptor, the engine writes the frame into the descriptor's buffer. It then writes a status word that returns the descriptor to software, and moves to the next descriptor.

Each descriptor uses four little-endian 32-bit words at a stride of 16 bytes. Word 0 (offset 0) is the control/status word. Bits [15:0] hold the received length, bit 28 flags a frame error, bit 29 flags truncation, bit 30 flags a bad buffer address, and bit 31 is the ownership flag (1 = hardware). Word 1 (offset 4) holds the buffer size in bits [15:0] and the end-of-ring flag in bit 31. Word 2 (offset 8) holds the buffer byte address. Word 3 is left to software. All memory traffic goes through a single-beat port: a request is held until it is acknowledged, and read data arrives with the acknowledge.

Top module: `rxr_engine`

## Requirements
- R1: After reset no memory request is pending and `s_ready` is low. The first frame after a `ring_init` pulse uses the descriptor at the captured ring base.
- R2: If ownership bit 31 of word 0 at the current descriptor is 0, the engine consumes the whole frame and makes no memory write. The next frame uses the same descriptor again.
- R3: Each stored frame byte n goes to buffer address + n. It is written as one single-beat write to the word-aligned address, with exactly one strobe set: lane (address + n) modulo 4.
- R4: After the frame's data writes, the engine writes word 0 with a full strobe. Bit 31 is 0, bits [15:0] hold the number of bytes stored, and the write goes to the descriptor it read.
- R5: If `s_err` is high on any accepted byte of a stored frame, bit 28 of the written-back word 0 is set.
- R6: A frame longer than the buffer size is cut at the buffer size, and extra bytes are accepted but not written. Bit 29 is set and the length equals the buffer size; a frame of exactly the buffer size is not flagged.
- R7: A buffer-size field of 0 selects the default size of 1536 bytes.
- R8: A buffer address whose bits [1:0] are not 2'b10 is rejected. No data byte is written, and the frame is consumed. Word 0 is written back as exactly bit 30 set with length 0, and the index advances.
- R9: After a descriptor whose word 1 bit 31 is set has been written back, the next descriptor is the one at the ring base. Otherwise it is the one 16 bytes further on.
- R10: A `ring_init` pulse captures `ring_base` and sets the ring index to 0.
- R11: A memory request keeps its address and direction unchanged until it is acknowledged.
- R12: While `rx_en` is low in the idle state, no frame is started: `s_ready` stays low and no memory request is issued. `s_ready` is never high while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Allows new frames to start |
| ring_init | input | 1 | Pulse: capture ring base, index to 0 |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_err | input | 1 | Frame marked bad by the MAC |
| s_ready | output | 1 | Engine accepts the stream byte |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Request is a write |
| m_addr | output | ADDR_W | Word-aligned byte address |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte-lane write strobes |
| m_ack | input | 1 | Request completed |
| m_rdata | input | DATA_W | Read data, valid with `m_ack` |

## Verification
Some rules are checked by assertions on every cycle:
- a request holds its address and direction until acknowledged;
- the stream is never accepted while a request is pending;
- every data write carries a single strobe lane;
- every writeback clears the ownership flag with a full strobe;
- the stored byte count stays within the buffer limit;
- the ring index is 0 after an init or a wrap.

Other behaviour only the bench scenarios can show:
- the skip-and-retry on a software-owned descriptor;
- the exact status words for error, truncation and bad-alignment frames;
- the default buffer size;
- which descriptor is used after a wrap or a base reload;
- the byte placement inside the buffers.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // descriptor layout: byte offsets of the words
  localparam int CTRL_OFS = 0;
  localparam int SIZE_OFS = 4;
  localparam int BUF_OFS  = 8;
  localparam int STRIDE_LG = 4;
  // control/status word bits
  localparam int OWN_BIT   = 31;
  localparam int BADBUF_BIT = 30;
  localparam int TRUNC_BIT = 29;
  localparam int FERR_BIT  = 28;
  // size word bits
  localparam int EOR_BIT   = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTRL, ST_RD_SIZE, ST_RD_BUF, ST_DATA, ST_DROP, ST_WB
  } rxr_state_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_init,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] desc_addr
);
  import rxr_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (ring_init) begin
      base_q <= ring_base;
      idx_q  <= '0;
    end else if (advance) begin
      idx_q <= wrap ? '0 : idx_q + 1'b1;
    end
  end

  assign desc_addr = base_q + (ADDR_W'(idx_q) << STRIDE_LG);

  a_r10_init_clears: assert property (@(posedge clk) disable iff (rst)
    ring_init |=> (idx_q == '0));
  a_r9_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
    (advance && wrap && !ring_init) |=> (desc_addr == base_q));
endmodule

// File: rtl/rxr_byte_lane.sv
module rxr_byte_lane #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DEFAULT_BUF = 1536
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [ADDR_W-1:0]   buf_addr,
  input  logic [LEN_W-1:0]    size_field,
  input  logic                step,
  output logic [ADDR_W-1:0]   waddr,
  output logic [DATA_W/8-1:0] wstrb,
  output logic [LEN_W-1:0]    cnt,
  output logic                full,
  output logic                addr_ok
);
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_LG = (LANES > 1) ? $clog2(LANES) : 1;

  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (load) begin
      cur_q   <= buf_addr;
      cnt_q   <= '0;
      limit_q <= (size_field == '0) ? LEN_W'(DEFAULT_BUF) : size_field;
    end else if (step) begin
      cur_q <= cur_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // buffer must be halfword aligned but not word aligned
  assign addr_ok = (buf_addr[1:0] == 2'b10);
  assign waddr   = {cur_q[ADDR_W-1:LANE_LG], {LANE_LG{1'b0}}};
  assign wstrb   = LANES'(1) << cur_q[LANE_LG-1:0];
  assign cnt     = cnt_q;
  assign full    = (cnt_q >= limit_q);

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit_q);
  a_r6_no_step_full: assert property (@(posedge clk) disable iff (rst)
    step |-> !full);
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 8,
  parameter int LEN_W       = 16,
  parameter int DEFAULT_BUF = 1536
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_en,
  input  logic                ring_init,
  input  logic [ADDR_W-1:0]   ring_base,
  input  logic                s_valid,
  input  logic [7:0]          s_data,
  input  logic                s_last,
  input  logic                s_err,
  output logic                s_ready,
  output logic                m_req,
  output logic                m_we,
  output logic [ADDR_W-1:0]   m_addr,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  input  logic                m_ack,
  input  logic [DATA_W-1:0]   m_rdata
);
  import rxr_pkg::*;

  localparam int LANES = DATA_W / 8;

  rxr_state_e        state_q;
  logic [ADDR_W-1:0] desc_addr;
  logic [LEN_W-1:0]  size_q;
  logic              eor_q, ferr_q, trunc_q, bad_q, last_q, wb_pend_q;

  logic [ADDR_W-1:0] lane_waddr;
  logic [LANES-1:0]  lane_strb;
  logic [LEN_W-1:0]  lane_cnt;
  logic              lane_full, lane_ok;
  logic              lane_load, lane_step, advance, accept;
  logic [DATA_W-1:0] wb_word;

  assign s_ready = ((state_q == ST_DATA) && !m_req && !last_q) ||
                   (state_q == ST_DROP);
  assign accept    = s_valid && s_ready;
  assign lane_load = (state_q == ST_RD_BUF) && m_ack;
  assign lane_step = (state_q == ST_DATA) && accept && !lane_full;
  assign advance   = (state_q == ST_WB) && m_ack;

  always_comb begin
    wb_word             = '0;
    wb_word[LEN_W-1:0]  = lane_cnt;
    wb_word[FERR_BIT]   = ferr_q;
    wb_word[TRUNC_BIT]  = trunc_q;
    wb_word[BADBUF_BIT] = bad_q;
    wb_word[OWN_BIT]    = 1'b0;
  end

  rxr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .ring_init(ring_init), .ring_base(ring_base),
    .advance(advance), .wrap(eor_q), .desc_addr(desc_addr)
  );

  rxr_byte_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                  .DEFAULT_BUF(DEFAULT_BUF)) u_lane (
    .clk(clk), .rst(rst), .load(lane_load), .buf_addr(m_rdata[ADDR_W-1:0]),
    .size_field(size_q), .step(lane_step), .waddr(lane_waddr),
    .wstrb(lane_strb), .cnt(lane_cnt), .full(lane_full), .addr_ok(lane_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      m_req     <= 1'b0;
      m_we      <= 1'b0;
      m_addr    <= '0;
      m_wdata   <= '0;
      m_wstrb   <= '0;
      size_q    <= '0;
      eor_q     <= 1'b0;
      ferr_q    <= 1'b0;
      trunc_q   <= 1'b0;
      bad_q     <= 1'b0;
      last_q    <= 1'b0;
      wb_pend_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (rx_en && s_valid && !ring_init) begin
            m_req     <= 1'b1;
            m_we      <= 1'b0;
            m_addr    <= desc_addr + ADDR_W'(CTRL_OFS);
            ferr_q    <= 1'b0;
            trunc_q   <= 1'b0;
            bad_q     <= 1'b0;
            last_q    <= 1'b0;
            wb_pend_q <= 1'b0;
            state_q   <= ST_RD_CTRL;
          end
        end
        ST_RD_CTRL: begin
          if (m_ack) begin
            if (m_rdata[OWN_BIT]) begin
              m_addr  <= desc_addr + ADDR_W'(SIZE_OFS);
              state_q <= ST_RD_SIZE;
            end else begin
              m_req   <= 1'b0;
              state_q <= ST_DROP;
            end
          end
        end
        ST_RD_SIZE: begin
          if (m_ack) begin
            size_q  <= m_rdata[LEN_W-1:0];
            eor_q   <= m_rdata[EOR_BIT];
            m_addr  <= desc_addr + ADDR_W'(BUF_OFS);
            state_q <= ST_RD_BUF;
          end
        end
        ST_RD_BUF: begin
          if (m_ack) begin
            m_req <= 1'b0;
            if (lane_ok) begin
              state_q <= ST_DATA;
            end else begin
              bad_q     <= 1'b1;
              wb_pend_q <= 1'b1;
              state_q   <= ST_DROP;
            end
          end
        end
        ST_DATA: begin
          if (m_req && m_ack) begin
            m_req <= 1'b0;
            m_we  <= 1'b0;
          end else if (!m_req && last_q) begin
            m_req   <= 1'b1;
            m_we    <= 1'b1;
            m_addr  <= desc_addr + ADDR_W'(CTRL_OFS);
            m_wdata <= wb_word;
            m_wstrb <= '1;
            state_q <= ST_WB;
          end
          if (accept) begin
            ferr_q <= ferr_q | s_err;
            last_q <= s_last;
            if (!lane_full) begin
              m_req   <= 1'b1;
              m_we    <= 1'b1;
              m_addr  <= lane_waddr;
              m_wdata <= {LANES{s_data}};
              m_wstrb <= lane_strb;
            end else begin
              trunc_q <= 1'b1;
            end
          end
        end
        ST_DROP: begin
          if (accept && s_last) begin
            if (wb_pend_q) begin
              m_req   <= 1'b1;
              m_we    <= 1'b1;
              m_addr  <= desc_addr + ADDR_W'(CTRL_OFS);
              m_wdata <= wb_word;
              m_wstrb <= '1;
              state_q <= ST_WB;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WB: begin
          if (m_ack) begin
            m_req   <= 1'b0;
            m_we    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));
  a_r12_ready_excl: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> !m_req);
  a_r12_idle_disabled: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !rx_en) |=> !m_req);
  a_r3_one_lane: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we && state_q == ST_DATA) |-> ($countones(m_wstrb) == 1));
  a_r4_wb_release: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we && state_q == ST_WB) |-> (!m_wdata[OWN_BIT] && (&m_wstrb)));
endmodule

// File: tb/test_rxr_engine.sv
module test_rxr_engine;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int MEM_WORDS = 4096;
  localparam logic [31:0] BASE  = 32'h100;
  localparam logic [31:0] BASE2 = 32'h300;

  typedef struct packed {
    logic        own;
    logic        eor;
    logic [15:0] bsz;
    logic [1:0]  boff;
    logic [7:0]  flen;
    logic        ferr;
    logic [31:0] exp_wb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'd0,  2'd2, 8'd12, 1'b0, 32'h0000000C},
    '{1'b1, 1'b0, 16'd64, 2'd2, 8'd1,  1'b1, 32'h10000001},
    '{1'b0, 1'b0, 16'd64, 2'd2, 8'd6,  1'b0, 32'h00000000},
    '{1'b1, 1'b0, 16'd5,  2'd2, 8'd9,  1'b0, 32'h20000005},
    '{1'b1, 1'b0, 16'd64, 2'd0, 8'd4,  1'b0, 32'h40000000},
    '{1'b1, 1'b1, 16'd64, 2'd2, 8'd7,  1'b1, 32'h10000007},
    '{1'b1, 1'b0, 16'd64, 2'd3, 8'd3,  1'b0, 32'h40000000},
    '{1'b1, 1'b0, 16'd8,  2'd2, 8'd8,  1'b1, 32'h10000008},
    '{1'b1, 1'b0, 16'd3,  2'd2, 8'd6,  1'b1, 32'h30000003},
    '{1'b1, 1'b0, 16'd64, 2'd1, 8'd2,  1'b0, 32'h40000000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, ring_init = 1'b0;
  logic [ADDR_W-1:0] ring_base = '0;
  logic s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, m_req, m_we;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [3:0] m_wstrb;
  logic m_ack = 1'b0;
  logic [DATA_W-1:0] m_rdata = '0;

  logic [31:0] mem [MEM_WORDS];
  int wr_cnt = 0;
  int n_chk = 0, n_fail = 0;
  int idx_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxr_engine i_rxr_engine (
    .clk(clk), .rst(rst), .rx_en(rx_en), .ring_init(ring_init),
    .ring_base(ring_base), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_err(s_err), .s_ready(s_ready), .m_req(m_req),
    .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_ack(m_ack), .m_rdata(m_rdata)
  );

  // single-beat memory: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (m_req && !m_ack) begin
      m_ack <= 1'b1;
      if (m_we) begin
        for (int b = 0; b < 4; b++)
          if (m_wstrb[b]) mem[m_addr[13:2]][b*8 +: 8] = m_wdata[b*8 +: 8];
        wr_cnt = wr_cnt + 1;
      end else begin
        m_rdata <= mem[m_addr[13:2]];
      end
    end else begin
      m_ack <= 1'b0;
    end
  end

  function automatic logic [7:0] rd8(input logic [31:0] a);
    return mem[a[13:2]][a[1:0]*8 +: 8];
  endfunction

  function automatic logic [7:0] fbyte(input int k, input int j);
    return 8'(k * 16 + j + 1);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic send_frame(input int k, input int n, input bit err);
    for (int j = 0; j < n; j++) begin
      s_valid = 1'b1;
      s_data  = fbyte(k, j);
      s_last  = (j == n - 1);
      s_err   = err && (j == n - 1);
      forever begin
        automatic logic got = s_ready;
        @(negedge clk);
        if (got) break;
      end
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    s_err   = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] d, input logic own, input logic eor,
                          input logic [15:0] bsz, input logic [31:0] baddr);
    mem[d[13:2]]       = {own, 31'b0};
    mem[d[13:2] + 1]   = {eor, 15'b0, bsz};
    mem[d[13:2] + 2]   = baddr;
    mem[d[13:2] + 3]   = 32'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < MEM_WORDS; w++) mem[w] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk("R1 m_req after reset", 32'(m_req), 32'h0);
    chk("R1 s_ready after reset", 32'(s_ready), 32'h0);

    ring_base = BASE;
    ring_init = 1'b1;
    @(negedge clk);
    ring_init = 1'b0;
    rx_en = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      automatic vec_t v = VECS[k];
      automatic logic [31:0] d = BASE + 32'(idx_m * 16);
      automatic logic [31:0] ba = 32'h800 + 32'(k * 64) + 32'(v.boff);
      automatic int lim = (v.bsz == 0) ? 1536 : int'(v.bsz);
      automatic bit bad = (v.boff != 2'd2);
      automatic int stored = (!v.own || bad) ? 0 : ((int'(v.flen) < lim) ? int'(v.flen) : lim);
      automatic string tag;
      if (k == 0) tag = "R1 R7";
      else if (!v.own) tag = "R2";
      else if (k == 6) tag = "R9 R8";
      else if (bad) tag = "R8";
      else if (int'(v.flen) > lim) tag = "R6";
      else if (v.ferr) tag = "R5";
      else tag = "R4";
      set_desc(d, v.own, v.eor, v.bsz, ba);
      for (int w = 0; w < 16; w++) mem[(32'h800 + k * 64) / 4 + w] = 32'h0;
      wr_cnt = 0;
      send_frame(k, int'(v.flen), v.ferr);
      repeat (30) @(negedge clk);
      chk($sformatf("%s vec %0d status word", tag, k), mem[d[13:2]], v.exp_wb);
      chk($sformatf("%s vec %0d write count", tag, k), 32'(wr_cnt),
          v.own ? 32'(stored + 1) : 32'h0);
      for (int j = 0; j < stored; j++)
        chk($sformatf("R3 vec %0d byte %0d", k, j), 32'(rd8(ba + 32'(j))), 32'(fbyte(k, j)));
      if (v.own && !bad && int'(v.flen) > lim)
        chk($sformatf("R6 vec %0d byte past limit", k), 32'(rd8(ba + 32'(stored))), 32'h0);
      if (v.own) idx_m = v.eor ? 0 : idx_m + 1;
    end

    // R12: disabled engine does not start a frame
    rx_en = 1'b0;
    s_valid = 1'b1;
    s_data = 8'h5A;
    s_last = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk("R12 s_ready while disabled", 32'(s_ready), 32'h0);
      chk("R12 m_req while disabled", 32'(m_req), 32'h0);
    end
    s_valid = 1'b0;
    s_last = 1'b0;

    // R10: reload the base while the index is 4
    ring_base = BASE2;
    ring_init = 1'b1;
    @(negedge clk);
    ring_init = 1'b0;
    rx_en = 1'b1;
    set_desc(BASE2, 1'b1, 1'b0, 16'd64, 32'hC02);
    wr_cnt = 0;
    send_frame(20, 4, 1'b0);
    repeat (30) @(negedge clk);
    chk("R10 status at new base", mem[BASE2[13:2]], 32'h00000004);
    chk("R10 old ring entry untouched", mem[(BASE + 32'd64) >> 2], 32'h10000007);
    chk("R10 write count", 32'(wr_cnt), 32'd5);

    // R7: zero size field gives 1536, a 40-byte frame is kept whole
    set_desc(BASE2 + 32'd16, 1'b1, 1'b0, 16'd0, 32'hD02);
    wr_cnt = 0;
    send_frame(21, 40, 1'b0);
    repeat (30) @(negedge clk);
    chk("R7 status long frame", mem[(BASE2 + 32'd16) >> 2], 32'h00000028);
    chk("R7 last byte stored", 32'(rd8(32'hD02 + 32'd39)), 32'(fbyte(21, 39)));
    chk("R7 write count", 32'(wr_cnt), 32'd41);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule